// File: doc/BRIEF.md
# Shift, Rotate and Bit Unit

This execution unit handles the bit-manipulation opcode page of an 8-bit processor core. Each cycle it can accept one operand with its opcode byte, the current carry flag and the current zero and sign flags. It returns the shifted, rotated or bit-modified result together with the updated flags, a writeback enable and the destination register field. All outputs are registered and appear one cycle after the input strobe.

The opcode byte carries three fields. Bits 7:6 pick the class. Bits 5:3 hold either the shift kind or the bit index. Bits 2:0 name the register to write back. Operand fetch and index-displacement addressing belong to the surrounding datapath. The data width is a parameter: a power of two of 8 or more, with the index field widened to match. The default is 8 bits.

Top module: `srb_top`

## Requirements
- R1: When `valid_i` is high on a clock edge, `valid_o` is high for the following cycle; otherwise it is low. `wb_en_o` is high only together with `valid_o`, and only for classes other than bit test.
- R2: Class 00 (bits 7:6), kind 000 (bits 5:3) rotates left circularly: old bit 7 goes to bit 0 and to carry. Kind 001 rotates right circularly: old bit 0 goes to bit 7 and to carry.
- R3: Kind 010 rotates left through carry: old bit 7 goes to carry, and the incoming carry goes to bit 0. Kind 011 rotates right through carry: old bit 0 goes to carry, and the incoming carry goes to bit 7.
- R4: Kind 100 shifts left and puts 0 into bit 0. Kind 110 shifts left and puts 1 into bit 0. In both, old bit 7 goes to carry.
- R5: Kind 101 shifts right and keeps bit 7. Kind 111 shifts right and puts 0 into bit 7. In both, old bit 0 goes to carry.
- R6: For class 00, zero is set exactly when the result is 0, and sign equals bit 7 of the result.
- R7: Class 01 tests the operand bit named by bits 5:3. Zero is set when that bit is 0. Carry and sign keep their input values, the result equals the operand, and no writeback is requested.
- R8: Class 10 clears the indexed bit and class 11 sets it. All other bits are kept. Carry, zero and sign keep their input values.
- R9: While `rst_ni` is low, `valid_o` and `wb_en_o` are low.
- R10: `reg_o` presents opcode bits 2:0 captured with the accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand and opcode strobe |
| opcode_i | input | OPC_W (8) | Class, kind or index, register field |
| operand_i | input | DATA_W (8) | Operand value |
| carry_i | input | 1 | Current carry flag |
| zero_i | input | 1 | Current zero flag |
| sign_i | input | 1 | Current sign flag |
| result_o | output | DATA_W (8) | Result value |
| carry_o | output | 1 | Updated carry flag |
| zero_o | output | 1 | Updated zero flag |
| sign_o | output | 1 | Updated sign flag |
| reg_o | output | 3 | Destination register field |
| wb_en_o | output | 1 | Writeback request |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |

## Verification
The bench builds the unit with the default 8-bit width, so the opcode byte covers every class, kind, index and register field. It streams every opcode against every operand value, one vector per cycle, with the incoming carry, zero and sign flags varied from vector to vector. This makes the sweep exhaustive over the whole instruction page and every data pattern. Both carry-in values reach the rotates through carry, and both states of each pass-through flag reach the bit operations.

// File: rtl/srb_pkg.sv
package srb_pkg;
  typedef enum logic [1:0] {
    CLS_SHIFT = 2'b00,
    CLS_TEST  = 2'b01,
    CLS_CLR   = 2'b10,
    CLS_SET   = 2'b11
  } cls_e;

  typedef enum logic [2:0] {
    K_ROL_CIRC = 3'b000,
    K_ROR_CIRC = 3'b001,
    K_ROL_CY   = 3'b010,
    K_ROR_CY   = 3'b011,
    K_SHL_ZERO = 3'b100,
    K_SHR_SIGN = 3'b101,
    K_SHL_ONE  = 3'b110,
    K_SHR_ZERO = 3'b111
  } kind_e;
endpackage

// File: rtl/srb_shift.sv
module srb_shift #(
  parameter int DATA_W = 8
) (
  input  srb_pkg::kind_e     kind_i,
  input  logic [DATA_W-1:0]  opnd_i,
  input  logic               cin_i,
  output logic [DATA_W-1:0]  res_o,
  output logic               cout_o
);
  import srb_pkg::*;

  localparam int MSB = DATA_W - 1;

  logic msb, lsb;
  assign msb = opnd_i[MSB];
  assign lsb = opnd_i[0];

  always_comb begin
    unique case (kind_i)
      K_ROL_CIRC: begin res_o = {opnd_i[MSB-1:0], msb};   cout_o = msb; end
      K_ROR_CIRC: begin res_o = {lsb, opnd_i[MSB:1]};     cout_o = lsb; end
      K_ROL_CY:   begin res_o = {opnd_i[MSB-1:0], cin_i}; cout_o = msb; end
      K_ROR_CY:   begin res_o = {cin_i, opnd_i[MSB:1]};   cout_o = lsb; end
      K_SHL_ZERO: begin res_o = {opnd_i[MSB-1:0], 1'b0};  cout_o = msb; end
      K_SHR_SIGN: begin res_o = {msb, opnd_i[MSB:1]};     cout_o = lsb; end
      K_SHL_ONE:  begin res_o = {opnd_i[MSB-1:0], 1'b1};  cout_o = msb; end
      default:    begin res_o = {1'b0, opnd_i[MSB:1]};    cout_o = lsb; end
    endcase
  end
endmodule

// File: rtl/srb_bitop.sv
module srb_bitop #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  srb_pkg::cls_e      cls_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [DATA_W-1:0]  opnd_i,
  output logic [DATA_W-1:0]  res_o,
  output logic               tbit_o
);
  import srb_pkg::*;

  logic [DATA_W-1:0] mask;

  // one-hot index decode
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (idx_i == IDX_W'(g));
  end

  assign tbit_o = |(opnd_i & mask);

  always_comb begin
    unique case (cls_i)
      CLS_CLR: res_o = opnd_i & ~mask;
      CLS_SET: res_o = opnd_i | mask;
      default: res_o = opnd_i;
    endcase
  end
endmodule

// File: rtl/srb_top.sv
module srb_top #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int OPC_W = 2 + IDX_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              carry_i,
  input  logic              zero_i,
  input  logic              sign_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              sign_o,
  output logic [2:0]        reg_o,
  output logic              wb_en_o,
  output logic              valid_o
);
  import srb_pkg::*;

  localparam int MSB = DATA_W - 1;

  cls_e             cls;
  kind_e            kind;
  logic [IDX_W-1:0] idx;

  assign cls  = cls_e'(opcode_i[OPC_W-1 -: 2]);
  assign idx  = opcode_i[3 +: IDX_W];
  assign kind = kind_e'(idx[2:0]);

  logic [DATA_W-1:0] sh_res, bit_res;
  logic              sh_cout, tbit;

  srb_shift #(.DATA_W(DATA_W)) u_shift (
    .kind_i (kind),
    .opnd_i (operand_i),
    .cin_i  (carry_i),
    .res_o  (sh_res),
    .cout_o (sh_cout)
  );

  srb_bitop #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bitop (
    .cls_i  (cls),
    .idx_i  (idx),
    .opnd_i (operand_i),
    .res_o  (bit_res),
    .tbit_o (tbit)
  );

  logic [DATA_W-1:0] res_d;
  logic              c_d, z_d, s_d, wb_d;

  always_comb begin
    unique case (cls)
      CLS_SHIFT: begin
        res_d = sh_res; c_d = sh_cout;
        z_d = (sh_res == '0); s_d = sh_res[MSB]; wb_d = 1'b1;
      end
      CLS_TEST: begin
        res_d = operand_i; c_d = carry_i;
        z_d = ~tbit; s_d = sign_i; wb_d = 1'b0;
      end
      default: begin
        res_d = bit_res; c_d = carry_i;
        z_d = zero_i; s_d = sign_i; wb_d = 1'b1;
      end
    endcase
  end

  logic wb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      zero_o   <= 1'b0;
      sign_o   <= 1'b0;
      reg_o    <= '0;
      wb_q     <= 1'b0;
    end else if (valid_i) begin
      result_o <= res_d;
      carry_o  <= c_d;
      zero_o   <= z_d;
      sign_o   <= s_d;
      reg_o    <= opcode_i[2:0];
      wb_q     <= wb_d;
    end
  end

  assign wb_en_o = valid_o & wb_q;

  p_strobe_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_wb_gated_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> valid_o);
  p_shift_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls == CLS_SHIFT) |=> (zero_o == (result_o == '0)) && (sign_o == result_o[MSB]));
  p_sra_sign_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls == CLS_SHIFT && kind == K_SHR_SIGN) |=> result_o[MSB] == $past(operand_i[MSB]));
  p_test_nowb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls == CLS_TEST) |=> !wb_en_o && result_o == $past(operand_i) && carry_o == $past(carry_i));
  p_bitop_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i[OPC_W-1]) |=> carry_o == $past(carry_i) && zero_o == $past(zero_i) && sign_o == $past(sign_i));
  p_bitop_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i[OPC_W-1]) |=> $countones(result_o ^ $past(operand_i)) <= 1);
  p_reg_field_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> reg_o == $past(opcode_i[2:0]));
endmodule

// File: tb/srb_top_bench.sv
module srb_top_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] opcode_i = '0;
  logic [7:0] operand_i = '0;
  logic       carry_i = 1'b0, zero_i = 1'b0, sign_i = 1'b0;
  logic [7:0] result_o;
  logic       carry_o, zero_o, sign_o, wb_en_o, valid_o;
  logic [2:0] reg_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  srb_top #(.DATA_W(8)) u_srb_top (
    .clk_i, .rst_ni, .valid_i, .opcode_i, .operand_i,
    .carry_i, .zero_i, .sign_i,
    .result_o, .carry_o, .zero_o, .sign_o, .reg_o, .wb_en_o, .valid_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // expected values straight from the requirements
  int e_res, e_c, e_z, e_s, e_wb, e_reg;
  string t_data, t_flag;

  task automatic model(input int op, input int a, input int ci, input int zi, input int si);
    int cls, k;
    cls = op >> 6;
    k   = (op >> 3) & 7;
    e_reg = op & 7;
    e_wb  = (cls != 1);
    if (cls == 0) begin
      case (k)
        0: begin e_res = ((a << 1) | (a >> 7)) & 255; e_c = a >> 7; t_data = "R2 rlc"; end
        1: begin e_res = (a >> 1) | ((a & 1) << 7);   e_c = a & 1;  t_data = "R2 rrc"; end
        2: begin e_res = ((a << 1) | ci) & 255;       e_c = a >> 7; t_data = "R3 rl";  end
        3: begin e_res = (a >> 1) | (ci << 7);        e_c = a & 1;  t_data = "R3 rr";  end
        4: begin e_res = (a << 1) & 255;              e_c = a >> 7; t_data = "R4 sl0"; end
        5: begin e_res = (a >> 1) | (a & 128);        e_c = a & 1;  t_data = "R5 sra"; end
        6: begin e_res = ((a << 1) | 1) & 255;        e_c = a >> 7; t_data = "R4 sl1"; end
        default: begin e_res = a >> 1;                e_c = a & 1;  t_data = "R5 srl"; end
      endcase
      e_z = (e_res == 0);
      e_s = e_res >> 7;
      t_flag = "R6 flags";
    end else if (cls == 1) begin
      e_res = a; e_c = ci; e_s = si;
      e_z = ((a >> k) & 1) == 0;
      t_data = "R7 test data"; t_flag = "R7 test flags";
    end else begin
      e_res = (cls == 2) ? (a & ~(1 << k) & 255) : (a | (1 << k));
      e_c = ci; e_z = zi; e_s = si;
      t_data = "R8 clr/set data"; t_flag = "R8 clr/set flags";
    end
  endtask

  initial begin
    bit pend = 0;
    int p_res, p_c, p_z, p_s, p_wb, p_reg;
    string p_td, p_tf;
    repeat (3) @(negedge clk_i);
    chk("R9 valid in reset", int'(valid_o), 0);
    chk("R9 wb in reset", int'(wb_en_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle valid", int'(valid_o), 0);
    for (int op = 0; op < 256; op++) begin
      for (int a = 0; a < 256; a++) begin
        @(negedge clk_i);
        if (pend) begin
          chk(p_td, int'(result_o), p_res);
          chk(p_td, int'(carry_o), p_c);
          chk(p_tf, int'({zero_o, sign_o}), p_z * 2 + p_s);
          chk("R1 strobe/wb", int'({valid_o, wb_en_o}), 2 + p_wb);
          chk("R10 reg field", int'(reg_o), p_reg);
        end
        opcode_i  = 8'(op);
        operand_i = 8'(a);
        carry_i   = a[0] ^ op[2] ^ a[5];
        zero_i    = a[1] ^ op[0];
        sign_i    = a[2] ^ op[1] ^ a[7];
        valid_i   = 1'b1;
        model(op, a, int'(carry_i), int'(zero_i), int'(sign_i));
        p_res = e_res; p_c = e_c; p_z = e_z; p_s = e_s;
        p_wb = e_wb; p_reg = e_reg; p_td = t_data; p_tf = t_flag;
        pend = 1;
      end
    end
    @(negedge clk_i);
    chk(p_td, int'(result_o), p_res);
    chk(p_tf, int'({zero_o, sign_o}), p_z * 2 + p_s);
    chk("R1 strobe/wb last", int'({valid_o, wb_en_o}), 2 + p_wb);
    valid_i = 1'b0;
    @(negedge clk_i);
    chk("R1 valid drops", int'(valid_o), 0);
    chk("R1 wb drops", int'(wb_en_o), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule